// File: doc/BRIEF.md
# Target Termination Timeout Timer

This block sits beside a bus target and decides when the target must abandon an access because data is too slow in coming. For every bus port it runs two latency timers. The first timer counts the clocks spent waiting for the first data word of an access. If that count reaches its threshold, the block asks for a RETRY termination. The second timer counts the clocks between data transfers once the first transfer has completed. If that count reaches its threshold, the block asks for a DISCONNECT.

Each threshold is an 8-bit programmable value. A threshold of zero switches its timer off. A typical setting is 16 clocks for first data and 8 clocks between transfers, but any value from 1 to 255 can be used. The block does not drive bus signals and does not decode the bus protocol. Surrounding logic tells it when an access starts, when the internal memory path has the first word ready, when each data word moves, and when the access ends normally. There is one independent copy of the logic for each bus port.

Top module: `tgt_term_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `retry_req`, `disc_req`, `first_pending`, `bursting` and `aborted` are all 0.
- R2: The cycle in which `txn_start` is high is cycle S. If `data_ready`, `data_xfer`, `txn_end` and `txn_start` stay low from S+1 onward, `retry_req` is 1 in cycle S+1+L, where L is a nonzero first threshold. It is 0 in every cycle before that.
- R3: In the bursting state, the last `data_xfer` falls in cycle X. If neither `data_xfer` nor `txn_end` nor `txn_start` is high after X, `disc_req` is 1 in cycle X+1+M, where M is a nonzero next threshold.
- R4: A threshold of 0 disables its timer. No RETRY (for the first threshold) or DISCONNECT (for the next threshold) is ever requested, however long the wait lasts, including waits longer than 255 cycles.
- R5: A `data_ready` in a cycle where the first timer has not yet fired stops that timer. No RETRY follows for that access.
- R6: Every `data_xfer` reloads the inter-transfer count to zero. The DISCONNECT window is therefore measured from the most recent transfer.
- R7: A request lasts exactly one cycle. After it, `aborted` is 1, and no other request is made until the next `txn_start`.
- R8: If `txn_end` is high in the cycle a timer would fire, no request is made. In the next cycle all status flags are 0.
- R9: Each port index uses only its own inputs and its own threshold slice (bits `[i*8 +: 8]`). Activity on one port never changes the outputs of another port.
- R10: `first_pending` is 1 from the cycle after `txn_start` until the first `data_xfer` or a termination. `bursting` is 1 after the first `data_xfer` until the access ends. At most one of `first_pending`, `bursting` and `aborted` is 1 on each port.
- R11: A `txn_start` during a running access restarts it: that cycle makes no request, and the first timer starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | PORTS | Address phase accepted, one bit per port |
| data_ready | input | PORTS | First data word available from the memory path |
| data_xfer | input | PORTS | A data word was transferred this cycle |
| txn_end | input | PORTS | Access ends normally this cycle |
| first_limit | input | PORTS*8 | First-data wait threshold per port, 0 = off |
| next_limit | input | PORTS*8 | Inter-transfer wait threshold per port, 0 = off |
| retry_req | output | PORTS | One-cycle RETRY request |
| disc_req | output | PORTS | One-cycle DISCONNECT request |
| first_pending | output | PORTS | Waiting for the first transfer |
| bursting | output | PORTS | First transfer done, access running |
| aborted | output | PORTS | Terminated by timeout, awaiting new start |

## Verification
A wrong count or a lost reload shows up at the ports as a RETRY or DISCONNECT pulse one or more cycles early or late, or as a pulse with a zero threshold. Such an error is visible in the very cycle the pulse should or should not appear. A wrong phase register shows up at once on the three status flags, or as a second pulse in the cycle after a termination. The model is compared against the outputs on every clock, so any of these faults is reported in the first cycle it becomes visible.

// File: rtl/tgt_term_pkg.sv
package tgt_term_pkg;

    localparam int unsigned LIM_W_DEF = 8;
    localparam int unsigned PORTS_DEF = 2;

    typedef enum logic [2:0] {
        PH_IDLE       = 3'd0,
        PH_WAIT_FIRST = 3'd1,
        PH_HAVE_FIRST = 3'd2,
        PH_BURST      = 3'd3,
        PH_ABORTED    = 3'd4
    } phase_e;

    typedef struct packed {
        logic start;
        logic ready;
        logic xfer;
        logic fin;
    } evt_t;

    typedef struct packed {
        logic retry;
        logic disc;
    } term_t;

    typedef struct packed {
        logic first_pending;
        logic bursting;
        logic aborted;
    } stat_t;

    typedef struct packed {
        logic first_clr;
        logic first_run;
        logic gap_clr;
        logic gap_run;
    } cnt_ctl_t;

    function automatic logic waiting_first(input phase_e ph);
        return (ph == PH_WAIT_FIRST) || (ph == PH_HAVE_FIRST);
    endfunction

    function automatic stat_t phase_to_stat(input phase_e ph);
        stat_t s;
        s.first_pending = waiting_first(ph);
        s.bursting      = (ph == PH_BURST);
        s.aborted       = (ph == PH_ABORTED);
        return s;
    endfunction

endpackage

// File: rtl/tgt_lat_counter.sv
module tgt_lat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic enabled;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (run && (count != CNT_MAX)) begin
            count <= count + CNT_ONE;
        end
    end

    always_comb begin
        enabled = (limit != '0);
        expired = enabled && (count == limit);
    end

endmodule

// File: rtl/tgt_phase_ctl.sv
module tgt_phase_ctl
    import tgt_term_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_t     evt,
    input  logic     first_hit,
    input  logic     gap_hit,
    output phase_e   phase,
    output term_t    term,
    output cnt_ctl_t ctl,
    output stat_t    stat
);
    phase_e phase_nxt;
    logic   quiet;

    always_comb begin
        quiet      = !evt.fin && !evt.start;
        term.retry = (phase == PH_WAIT_FIRST) && first_hit && quiet
                     && !evt.ready && !evt.xfer;
        term.disc  = (phase == PH_BURST) && gap_hit && quiet && !evt.xfer;
    end

    always_comb begin
        phase_nxt = phase;
        if (evt.start) begin
            phase_nxt = PH_WAIT_FIRST;
        end else if (evt.fin) begin
            phase_nxt = PH_IDLE;
        end else if (term.retry || term.disc) begin
            phase_nxt = PH_ABORTED;
        end else begin
            unique case (phase)
                PH_WAIT_FIRST: begin
                    if (evt.xfer)       phase_nxt = PH_BURST;
                    else if (evt.ready) phase_nxt = PH_HAVE_FIRST;
                end
                PH_HAVE_FIRST: begin
                    if (evt.xfer) phase_nxt = PH_BURST;
                end
                default: phase_nxt = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    always_comb begin
        ctl.first_clr = evt.start;
        ctl.first_run = (phase == PH_WAIT_FIRST);
        ctl.gap_clr   = evt.start || evt.xfer || (phase != PH_BURST);
        ctl.gap_run   = (phase == PH_BURST);
        stat          = phase_to_stat(phase);
    end

endmodule

// File: rtl/tgt_term_port.sv
module tgt_term_port
    import tgt_term_pkg::*;
#(
    parameter int unsigned W = LIM_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt,
    input  logic [W-1:0] first_limit,
    input  logic [W-1:0] next_limit,
    output term_t        term,
    output stat_t        stat
);
    phase_e       phase;
    cnt_ctl_t     ctl;
    logic         first_hit;
    logic         gap_hit;
    logic [W-1:0] first_cnt;
    logic [W-1:0] gap_cnt;

    tgt_lat_counter #(.W(W)) u_first (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.first_clr),
        .run     (ctl.first_run),
        .limit   (first_limit),
        .count   (first_cnt),
        .expired (first_hit)
    );

    tgt_lat_counter #(.W(W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.gap_clr),
        .run     (ctl.gap_run),
        .limit   (next_limit),
        .count   (gap_cnt),
        .expired (gap_hit)
    );

    tgt_phase_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .first_hit (first_hit),
        .gap_hit   (gap_hit),
        .phase     (phase),
        .term      (term),
        .ctl       (ctl),
        .stat      (stat)
    );

endmodule

// File: rtl/tgt_term_timer.sv
module tgt_term_timer
    import tgt_term_pkg::*;
#(
    parameter int unsigned PORTS = PORTS_DEF,
    parameter int unsigned W     = LIM_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PORTS-1:0]   txn_start,
    input  logic [PORTS-1:0]   data_ready,
    input  logic [PORTS-1:0]   data_xfer,
    input  logic [PORTS-1:0]   txn_end,
    input  logic [PORTS*W-1:0] first_limit,
    input  logic [PORTS*W-1:0] next_limit,
    output logic [PORTS-1:0]   retry_req,
    output logic [PORTS-1:0]   disc_req,
    output logic [PORTS-1:0]   first_pending,
    output logic [PORTS-1:0]   bursting,
    output logic [PORTS-1:0]   aborted
);
    for (genvar i = 0; i < PORTS; i++) begin : g_port
        evt_t  evt;
        term_t term;
        stat_t stat;

        always_comb begin
            evt.start = txn_start[i];
            evt.ready = data_ready[i];
            evt.xfer  = data_xfer[i];
            evt.fin   = txn_end[i];
        end

        tgt_term_port #(.W(W)) u_port (
            .clk         (clk),
            .rst         (rst),
            .evt         (evt),
            .first_limit (first_limit[i*W +: W]),
            .next_limit  (next_limit[i*W +: W]),
            .term        (term),
            .stat        (stat)
        );

        assign retry_req[i]     = term.retry;
        assign disc_req[i]      = term.disc;
        assign first_pending[i] = stat.first_pending;
        assign bursting[i]      = stat.bursting;
        assign aborted[i]       = stat.aborted;
    end

endmodule

// File: rtl/tgt_term_checker.sv
module tgt_term_checker #(
    parameter int unsigned PORTS = 2,
    parameter int unsigned W     = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [PORTS-1:0]   txn_start,
    input logic [PORTS-1:0]   data_ready,
    input logic [PORTS-1:0]   data_xfer,
    input logic [PORTS-1:0]   txn_end,
    input logic [PORTS*W-1:0] first_limit,
    input logic [PORTS*W-1:0] next_limit,
    input logic [PORTS-1:0]   retry_req,
    input logic [PORTS-1:0]   disc_req,
    input logic [PORTS-1:0]   first_pending,
    input logic [PORTS-1:0]   bursting,
    input logic [PORTS-1:0]   aborted
);
    for (genvar i = 0; i < PORTS; i++) begin : g_chk
        assert_retry_while_waiting_R2: assert property (@(posedge clk) disable iff (rst)
            retry_req[i] |-> (first_pending[i] && !data_ready[i] && !data_xfer[i]));

        assert_disc_while_bursting_R3: assert property (@(posedge clk) disable iff (rst)
            disc_req[i] |-> (bursting[i] && !data_xfer[i]));

        assert_zero_first_off_R4: assert property (@(posedge clk) disable iff (rst)
            (first_limit[i*W +: W] == '0) |-> !retry_req[i]);

        assert_zero_next_off_R4: assert property (@(posedge clk) disable iff (rst)
            (next_limit[i*W +: W] == '0) |-> !disc_req[i]);

        assert_one_cycle_pulse_R7: assert property (@(posedge clk) disable iff (rst)
            (retry_req[i] || disc_req[i]) |=> (aborted[i] && !retry_req[i] && !disc_req[i]));

        assert_silent_after_abort_R7: assert property (@(posedge clk) disable iff (rst)
            (aborted[i] && !txn_start[i]) |-> !(retry_req[i] || disc_req[i]));

        assert_end_wins_R8: assert property (@(posedge clk) disable iff (rst)
            txn_end[i] |-> !(retry_req[i] || disc_req[i]));

        assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
            $onehot0({first_pending[i], bursting[i], aborted[i]}));

        assert_start_no_request_R11: assert property (@(posedge clk) disable iff (rst)
            txn_start[i] |-> !(retry_req[i] || disc_req[i]));
    end
endmodule

bind tgt_term_timer tgt_term_checker #(.PORTS(PORTS), .W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .txn_start     (txn_start),
    .data_ready    (data_ready),
    .data_xfer     (data_xfer),
    .txn_end       (txn_end),
    .first_limit   (first_limit),
    .next_limit    (next_limit),
    .retry_req     (retry_req),
    .disc_req      (disc_req),
    .first_pending (first_pending),
    .bursting      (bursting),
    .aborted       (aborted)
);

// File: tb/sim_tgt_term_timer.sv
module sim_tgt_term_timer;
    localparam int P = 2;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [P-1:0]   txn_start = '0, data_ready = '0, data_xfer = '0, txn_end = '0;
    logic [P*W-1:0] first_limit = '0, next_limit = '0;
    logic [P-1:0]   retry_req, disc_req, first_pending, bursting, aborted;

    int vectors = 0;
    int fails   = 0;
    // behavioural model: 0 idle, 1 waiting first, 2 first ready, 3 burst, 4 aborted
    int st[P];
    int wt[P];
    int gp[P];

    always #10 clk = ~clk;

    tgt_term_timer #(.PORTS(P), .W(W)) u0 (
        .clk(clk), .rst(rst), .txn_start(txn_start), .data_ready(data_ready),
        .data_xfer(data_xfer), .txn_end(txn_end), .first_limit(first_limit),
        .next_limit(next_limit), .retry_req(retry_req), .disc_req(disc_req),
        .first_pending(first_pending), .bursting(bursting), .aborted(aborted)
    );

    function automatic int fl(int p); return int'(first_limit[p*W +: W]); endfunction
    function automatic int nl(int p); return int'(next_limit[p*W +: W]); endfunction

    function automatic bit exp_retry(int p);
        return st[p] == 1 && fl(p) != 0 && wt[p] == fl(p) && !data_ready[p]
               && !data_xfer[p] && !txn_end[p] && !txn_start[p];
    endfunction

    function automatic bit exp_disc(int p);
        return st[p] == 3 && nl(p) != 0 && gp[p] == nl(p) && !data_xfer[p]
               && !txn_end[p] && !txn_start[p];
    endfunction

    task automatic compare();
        for (int p = 0; p < P; p++) begin
            bit er, ed, ef, eb, ea;
            er = exp_retry(p);
            ed = exp_disc(p);
            ef = (st[p] == 1 || st[p] == 2);
            eb = (st[p] == 3);
            ea = (st[p] == 4);
            vectors++;
            // R2 R4 R5 R8 R9 R11: retry timing per port
            if (retry_req[p] !== er) begin
                fails++;
                $display("FAIL R2 port %0d retry_req got %b exp %b at %0t", p, retry_req[p], er, $time);
            end
            // R3 R4 R6 R7: disconnect timing
            if (disc_req[p] !== ed) begin
                fails++;
                $display("FAIL R3 port %0d disc_req got %b exp %b at %0t", p, disc_req[p], ed, $time);
            end
            // R10 status flags
            if ({first_pending[p], bursting[p], aborted[p]} !== {ef, eb, ea}) begin
                fails++;
                $display("FAIL R10 port %0d flags got %b exp %b at %0t", p,
                         {first_pending[p], bursting[p], aborted[p]}, {ef, eb, ea}, $time);
            end
        end
    endtask

    task automatic advance();
        for (int p = 0; p < P; p++) begin
            bit r, d;
            r = exp_retry(p);
            d = exp_disc(p);
            if (txn_start[p]) begin st[p] = 1; wt[p] = 0; end
            else if (txn_end[p]) st[p] = 0;
            else if (r || d) st[p] = 4;
            else if (st[p] == 1) begin
                if (data_xfer[p]) begin st[p] = 3; gp[p] = 0; end
                else if (data_ready[p]) st[p] = 2;
                else if (wt[p] < 255) wt[p]++;
            end else if (st[p] == 2) begin
                if (data_xfer[p]) begin st[p] = 3; gp[p] = 0; end
            end else if (st[p] == 3) begin
                if (data_xfer[p]) gp[p] = 0;
                else if (gp[p] < 255) gp[p]++;
            end
        end
    endtask

    // inputs are set 2 ns after a rising edge; compare at the falling edge
    task automatic cyc();
        #8 compare();
        @(posedge clk);
        advance();
        #2;
    endtask

    task automatic setp(int p, bit s, bit r, bit x, bit e);
        txn_start[p] = s; data_ready[p] = r; data_xfer[p] = x; txn_end[p] = e;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            txn_start = '0; data_ready = '0; data_xfer = '0; txn_end = '0;
            cyc();
        end
    endtask

    task automatic lims(int p, int f, int n);
        first_limit[p*W +: W] = W'(f);
        next_limit[p*W +: W]  = W'(n);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < P; p++) begin st[p] = 0; wt[p] = 0; gp[p] = 0; end
        @(posedge clk); #2;
        // R1: reset state checked while rst high
        for (int k = 0; k < 3; k++) cyc();
        rst = 1'b0;
        idle(2);

        // R2: first data never comes, threshold 16
        lims(0, 16, 8); lims(1, 16, 8);
        setp(0, 1, 0, 0, 0); cyc(); idle(20);
        // R7: further idling after abort gives no pulse
        idle(5); setp(0, 0, 0, 0, 1); cyc(); idle(1);

        // R3 + R6: burst with gaps shorter than 8, then a long gap
        setp(0, 1, 0, 0, 0); cyc(); idle(3);
        setp(0, 0, 1, 0, 0); cyc(); idle(2);
        setp(0, 0, 0, 1, 0); cyc(); idle(6);
        setp(0, 0, 0, 1, 0); cyc(); idle(7);
        setp(0, 0, 0, 1, 0); cyc(); idle(12);

        // R4: both thresholds zero, 300 idle cycles in each phase
        lims(0, 0, 0);
        setp(0, 1, 0, 0, 0); cyc(); idle(300);
        setp(0, 0, 0, 1, 0); cyc(); idle(300);
        setp(0, 0, 0, 0, 1); cyc();

        // R5: ready before expiry, long wait afterwards
        lims(0, 4, 3);
        setp(0, 1, 0, 0, 0); cyc(); idle(3);
        setp(0, 0, 1, 0, 0); cyc(); idle(10);
        setp(0, 0, 0, 0, 1); cyc();

        // R8: txn_end in the cycle the first timer would fire
        setp(0, 1, 0, 0, 0); cyc(); idle(4);
        setp(0, 0, 0, 0, 1); cyc(); idle(3);
        // R8: txn_end in the cycle the gap timer would fire
        setp(0, 1, 0, 0, 0); cyc();
        setp(0, 0, 0, 1, 0); cyc(); idle(3);
        setp(0, 0, 0, 0, 1); cyc(); idle(2);

        // R11: restart during a running access
        setp(0, 1, 0, 0, 0); cyc(); idle(3);
        setp(0, 1, 0, 0, 0); cyc(); idle(6);

        // R9: ports with different thresholds running together
        lims(0, 2, 2); lims(1, 9, 5);
        txn_start = 2'b11; cyc(); idle(12);
        txn_start = 2'b10; cyc(); idle(1);
        data_xfer = 2'b10; cyc(); idle(8);

        // mixed random traffic on both ports
        for (int k = 0; k < 6000; k++) begin
            if (k % 500 == 0)
                for (int p = 0; p < P; p++) lims(p, $urandom_range(0, 6), $urandom_range(0, 5));
            for (int p = 0; p < P; p++) begin
                int r;
                r = $urandom_range(0, 99);
                setp(p, r < 6, (r >= 6 && r < 14), (r >= 14 && r < 30), (r >= 30 && r < 34));
            end
            cyc();
        end
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule